// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns four external interrupt pins into interrupt requests. Each pin is brought into the system clock domain through a multi-flop synchronizer. It is then classified by its own 2-bit sense field, which selects a live low-level request or one of three kinds of edge event. Edge events are latched in per-pin pending flags. A flag clears through a write-one-to-clear port or through a per-pin acknowledge pulse.

Each pin's request is gated by a per-pin enable mask and by a global enable. The block also drives one combined request line. The sense fields sit in one 8-bit control register. The lowest pin of the group uses bits 1:0 and the highest uses bits 7:6. Edge detection compares two successive synchronized samples. The previous-sample register runs in every mode, so switching modes never acts on a stale sample.

Top module: `ext_irq_sense`

## Requirements
- R1: The control register resets to 0 and reads back the last value written. Pin index k (k = 0..3) is governed by bits [2k+1:2k].
- R2: Sense codes: 2'b00 is low level, 2'b01 is any change, 2'b10 is falling edge, 2'b11 is rising edge. An edge code sets pin k's pending flag only on its own kind of transition.
- R3: In low-level mode (2'b00) the request follows the synchronized pin. It is high while the pin is low and drops when the pin rises. It never sets the pending flag.
- R4: `irq_any_o` is high exactly when at least one bit of `irq_o` is high.
- R5: `irq_o[k]` is (pending[k] or active low level[k]) AND `mask_i[k]` AND `gie_i`. The pending flag is still set while the pin is masked or the global enable is low.
- R6: A pending flag clears on `ack_i[k]`, or on `flag_clr_we_i` with `flag_clr_data_i[k]`=1. Data without the write strobe, and ones in other bit positions, leave it unchanged. A set in the same cycle as a clear wins.
- R7: A pin change driven between clock edges shows on `pending_o` after the third following rising edge and not after the second. A low level shows on `irq_o` after the second edge and not after the first.
- R8: A control write shows on `ctrl_rdata_o` after the next edge. With the pin's mask bit cleared first, changing its sense field while the pin is steady raises no request and sets no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 4 | External interrupt pins (asynchronous) |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register contents |
| mask_i | input | 4 | Per-pin request enable |
| gie_i | input | 1 | Global request enable |
| flag_clr_we_i | input | 1 | Pending flag write-one-to-clear strobe |
| flag_clr_data_i | input | 4 | Flags to clear when strobed |
| ack_i | input | 4 | Per-pin acknowledge, clears pending flag |
| pending_o | output | 4 | Pending flags |
| irq_o | output | 4 | Gated per-pin requests |
| irq_any_o | output | 1 | OR of all per-pin requests |

## Verification
The two functions that can fall in the same cycle are a new edge event setting a pending flag and an acknowledge clearing that same flag. The bench first leaves a flag pending in any-change mode. It then toggles the pin and asserts the acknowledge for exactly the edge at which the synchronized event registers, counted as the third edge after the pin change. The flag must still read one after that edge and must fall only on a later, lone acknowledge. A bound checker also confirms, cycle by cycle, that every flag cleared without a coincident event reads zero on the next cycle.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int SENSE_W = 2;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eis_edge_detect.sv
module eis_edge_detect
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   smp_i,
  input  sense_e mode_i,
  output logic   evt_o,
  output logic   lvl_o
);
  logic prev_q;
  logic rise, fall;

  // runs in every mode so a mode switch never sees a stale sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= smp_i;
  end

  assign rise = smp_i & ~prev_q;
  assign fall = ~smp_i & prev_q;

  always_comb begin
    unique case (mode_i)
      SENSE_ANY:  evt_o = rise | fall;
      SENSE_FALL: evt_o = fall;
      SENSE_RISE: evt_o = rise;
      default:    evt_o = 1'b0;
    endcase
  end

  assign lvl_o = (mode_i == SENSE_LOW) & ~smp_i;
endmodule

// File: rtl/eis_pending.sv
module eis_pending #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pend_q;

  // set dominates a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign q_o = pend_q;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CTRL_W     = NUM_PINS * SENSE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                ctrl_we_i,
  input  logic [CTRL_W-1:0]   ctrl_wdata_i,
  output logic [CTRL_W-1:0]   ctrl_rdata_o,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic                gie_i,
  input  logic                flag_clr_we_i,
  input  logic [NUM_PINS-1:0] flag_clr_data_i,
  input  logic [NUM_PINS-1:0] ack_i,
  output logic [NUM_PINS-1:0] pending_o,
  output logic [NUM_PINS-1:0] irq_o,
  output logic                irq_any_o
);
  logic [CTRL_W-1:0]   ctrl_q;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] evt_set;
  logic [NUM_PINS-1:0] lvl_act;
  logic [NUM_PINS-1:0] clr_vec;
  logic [NUM_PINS-1:0] pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
  end
  assign ctrl_rdata_o = ctrl_q;

  eis_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pin_sync)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    eis_edge_detect u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (pin_sync[i]),
      .mode_i (sense_e'(ctrl_q[i*SENSE_W +: SENSE_W])),
      .evt_o  (evt_set[i]),
      .lvl_o  (lvl_act[i])
    );
  end

  assign clr_vec = ({NUM_PINS{flag_clr_we_i}} & flag_clr_data_i) | ack_i;

  eis_pending #(.WIDTH(NUM_PINS)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set),
    .clr_i  (clr_vec),
    .q_o    (pend)
  );

  assign pending_o = pend;
  assign irq_o     = (pend | lvl_act) & mask_i & {NUM_PINS{gie_i}};
  assign irq_any_o = |irq_o;
endmodule

// File: rtl/eis_checker.sv
module eis_checker #(
  parameter int NUM_PINS = 4,
  parameter int CTRL_W   = 2 * NUM_PINS
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ctrl_we_i,
  input logic [CTRL_W-1:0]   ctrl_wdata_i,
  input logic [CTRL_W-1:0]   ctrl_rdata_o,
  input logic [NUM_PINS-1:0] mask_i,
  input logic                gie_i,
  input logic                flag_clr_we_i,
  input logic [NUM_PINS-1:0] flag_clr_data_i,
  input logic [NUM_PINS-1:0] ack_i,
  input logic [NUM_PINS-1:0] pending_o,
  input logic [NUM_PINS-1:0] irq_o,
  input logic                irq_any_o,
  input logic [NUM_PINS-1:0] evt_i
);
  logic [NUM_PINS-1:0] clr_v;
  logic [NUM_PINS-1:0] lvl_mode;
  logic [NUM_PINS-1:0] gate_v;

  assign clr_v  = (flag_clr_we_i ? flag_clr_data_i : '0) | ack_i;
  assign gate_v = gie_i ? mask_i : '0;
  always_comb begin
    for (int i = 0; i < NUM_PINS; i++)
      lvl_mode[i] = (ctrl_rdata_o[2*i +: 2] == 2'b00);
  end

  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> ctrl_rdata_o == $past(ctrl_wdata_i)); // R8
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_rdata_o)); // R1
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~gate_v) == '0); // R5
  AST_ANY_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(irq_o) == 0) |-> !irq_any_o); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pending_o & $past(clr_v & ~evt_i)) == '0); // R6
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pending_o & $past(evt_i)) == $past(evt_i)); // R6
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pending_o & ~$past(pending_o) & $past(lvl_mode)) == '0); // R3
endmodule

bind ext_irq_sense eis_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ctrl_we_i       (ctrl_we_i),
  .ctrl_wdata_i    (ctrl_wdata_i),
  .ctrl_rdata_o    (ctrl_rdata_o),
  .mask_i          (mask_i),
  .gie_i           (gie_i),
  .flag_clr_we_i   (flag_clr_we_i),
  .flag_clr_data_i (flag_clr_data_i),
  .ack_i           (ack_i),
  .pending_o       (pending_o),
  .irq_o           (irq_o),
  .irq_any_o       (irq_any_o),
  .evt_i           (evt_set)
);

// File: tb/tb_ext_irq_sense.sv
`timescale 1ns/1ps
module tb_ext_irq_sense;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic [N-1:0] pins;
  logic         ctrl_we;
  logic [7:0]   ctrl_wdata;
  logic [7:0]   ctrl_rdata;
  logic [N-1:0] mask;
  logic         gie;
  logic         clr_we;
  logic [N-1:0] clr_data;
  logic [N-1:0] ack;
  logic [N-1:0] pending;
  logic [N-1:0] irq;
  logic         irq_any;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_irq_sense dut (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .mask_i(mask), .gie_i(gie),
    .flag_clr_we_i(clr_we), .flag_clr_data_i(clr_data), .ack_i(ack),
    .pending_o(pending), .irq_o(irq), .irq_any_o(irq_any)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    tick(1);
    ctrl_we = 1'b0;
  endtask

  task automatic clr_all();
    clr_we = 1'b1; clr_data = '1;
    tick(1);
    clr_we = 1'b0; clr_data = '0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; pins = '1; ctrl_we = 0; ctrl_wdata = '0; mask = '1; gie = 1;
    clr_we = 0; clr_data = '0; ack = '0;
    tick(3);
    rst_ni = 1'b1;
    tick(4);
    // R1 reset state; R3 synchronizer ramp in level mode latches nothing
    chk(ctrl_rdata == 8'h00, "R1 reset ctrl", ctrl_rdata, 0);
    chk(pending == '0, "R3 reset pending", pending, 0);
    chk(irq == '0 && !irq_any, "R3 reset irq", irq, 0);

    // R2 sweep: every pin in every mode, both transitions
    for (int p = 0; p < N; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] cv;
        logic ep, ei;
        string tg;
        tg = (m == 0) ? "R3" : "R2";
        cv = (8'hFF & ~(8'h03 << (2*p))) | (8'(m) << (2*p));
        wr_ctrl(cv);
        tick(4); clr_all(); tick(1);
        chk(ctrl_rdata == cv, "R1 readback", ctrl_rdata, cv);
        pins[p] = 1'b0;
        tick(4);
        ep = (m == 1) || (m == 2);
        ei = ep || (m == 0);
        chk(pending == (4'(ep) << p), {tg, " fall pending"}, pending, 4'(ep) << p);
        chk(irq == (4'(ei) << p), {tg, " fall irq"}, irq, 4'(ei) << p);
        chk(irq_any == ei, "R4 any after fall", irq_any, ei);
        clr_all(); tick(1);
        pins[p] = 1'b1;
        tick(4);
        ep = (m == 1) || (m == 3);
        chk(pending == (4'(ep) << p), {tg, " rise pending"}, pending, 4'(ep) << p);
        chk(irq == (4'(ep) << p), {tg, " rise irq"}, irq, 4'(ep) << p);
        chk(irq_any == ep, "R4 any after rise", irq_any, ep);
        clr_all(); tick(1);
      end
    end

    // R7 edge latency, pin 0 falling-edge mode
    wr_ctrl(8'hFE); tick(4); clr_all(); tick(1);
    pins[0] = 1'b0;
    tick(2);
    chk(pending[0] == 1'b0, "R7 edge not after 2 edges", pending, 0);
    tick(1);
    chk(pending[0] == 1'b1, "R7 edge after 3 edges", pending, 1);
    pins[0] = 1'b1; tick(4); clr_all(); tick(1);

    // R7 level latency; R3 drop without latching
    wr_ctrl(8'hFC); tick(4);
    pins[0] = 1'b0;
    tick(1);
    chk(irq[0] == 1'b0, "R7 level not after 1 edge", irq, 0);
    tick(1);
    chk(irq[0] == 1'b1, "R7 level after 2 edges", irq, 1);
    pins[0] = 1'b1;
    tick(2);
    chk(irq == '0 && pending == '0, "R3 level drop unlatched", {pending, irq}, 0);

    // R5 masking and global enable
    wr_ctrl(8'hFE); tick(4); clr_all(); tick(1);
    mask = 4'b1110;
    pins[0] = 1'b0; tick(4);
    chk(irq[0] == 1'b0, "R5 masked irq", irq, 0);
    chk(pending[0] == 1'b1, "R5 masked still pending", pending, 1);
    mask = '1; #1;
    chk(irq[0] == 1'b1 && irq_any, "R5 unmask irq", irq, 1);
    gie = 1'b0; #1;
    chk(irq == '0 && !irq_any, "R5 gie off", irq, 0);
    gie = 1'b1;
    pins[0] = 1'b1; tick(4); clr_all(); tick(1);

    // R6 clears, ignored writes, set wins
    wr_ctrl(8'hFD); tick(4); clr_all(); tick(1);
    pins[0] = 1'b0; tick(4);
    chk(pending[0] == 1'b1, "R6 setup pending", pending, 1);
    clr_data = 4'b0001; tick(1); clr_data = '0;
    chk(pending[0] == 1'b1, "R6 data without strobe ignored", pending, 1);
    clr_we = 1'b1; clr_data = 4'b0010; tick(1); clr_we = 0; clr_data = '0;
    chk(pending[0] == 1'b1, "R6 other bit ignored", pending, 1);
    pins[0] = 1'b1; tick(2);
    ack = 4'b0001; tick(1); ack = '0;
    chk(pending[0] == 1'b1, "R6 set wins over ack", pending, 1);
    ack = 4'b0001; tick(1); ack = '0;
    chk(pending[0] == 1'b0, "R6 ack clears", pending, 0);
    pins[0] = 1'b0; tick(4);
    clr_we = 1'b1; clr_data = 4'b0001; tick(1); clr_we = 0; clr_data = '0;
    chk(pending[0] == 1'b0, "R6 w1c clears", pending, 0);

    // R8 mode change with pin masked, pin held low
    wr_ctrl(8'hFC); tick(3);
    chk(irq[0] == 1'b1, "R8 level active before change", irq, 1);
    mask = 4'b1110; #1;
    chk(irq[0] == 1'b0, "R8 masked before change", irq, 0);
    wr_ctrl(8'hFD);
    chk(ctrl_rdata == 8'hFD, "R8 write next clock", ctrl_rdata, 8'hFD);
    tick(4);
    chk(irq == '0, "R8 no request after change", irq, 0);
    chk(pending == '0, "R8 no spurious pending", pending, 0);
    mask = '1; #1;
    chk(irq == '0 && !irq_any, "R8 unmasked no request", irq, 0);
    pins[0] = 1'b1; tick(4);
    chk(pending[0] == 1'b1 && irq_any, "R8 new mode live", pending, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule